// File: doc/BRIEF.md
# Radix-2 Butterfly Element with Three-Multiplier Twiddle Rotation

This block is the arithmetic core of a 64-point FFT or IFFT engine. Each valid cycle it accepts two complex 16-bit samples, a twiddle index and a direction bit. It returns two complex results. The upper leg is the sum of the two samples, halved. The lower leg is the difference of the two samples, rotated by a unit-circle factor.

The rotation does not use the usual four real products. It first forms the difference R = a − b. It then computes one shared product, (Rr − Ri)·Wi, and two further products, Rr·(Wr − Wi) and Ri·(Wr + Wi). The real part is the shared product plus the second. The imaginary part is the shared product plus the third. So three multipliers do the work of four, at the cost of a few extra adders.

The twiddle values come from a constant table. It is built from a 17-entry quarter-wave cosine list, so nothing is computed at run time. The inverse direction uses the conjugate factor. Sequencing, memory addressing and reordering of an FFT frame belong to the surrounding engine.

Top module: `bfly3m_pe`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and all four data outputs are 0.
- R2: A sample accepted with `in_valid` high on a rising edge produces `out_valid` high just after the second following rising edge (three register stages). `out_valid` is low for every other cycle.
- R3: `up_re`/`up_im` equal floor((a + b + 1) / 2), computed per component from the accepted sample.
- R4: `lo_re` equals the real part of (a − b)·W. The exact result is rounded by adding 2^13 and arithmetic shifting right by 14. The result is then clamped to [−32768, 32767].
- R5: `lo_im` equals the imaginary part of (a − b)·W, with the same rounding and clamping as R4.
- R6: For index k in 0..31 and `inv` = 0, W has real part round(16384·cos(2πk/64)) and imaginary part −round(16384·sin(2πk/64)). These are Q1.14 values, and `tw_idx` is read as an unsigned 5-bit number.
- R7: With `inv` = 1, the imaginary part of W is negated, giving the conjugate of the R6 factor. The real part is unchanged.
- R8: When a rotated result lies outside the 16-bit range, the lower-leg output is exactly 32767 (positive excess) or −32768 (negative excess).
- R9: On any cycle where `out_valid` is low, all four data outputs keep the values they had on the previous cycle.
- R10: Data presented while `in_valid` is low is not taken in. It never reaches the outputs, and it does not disturb results already in flight.
- R11: Boundary indices behave as a pure pass and a pure quarter turn. At k = 0 the lower leg is a − b. At k = 16 (forward) it is (Ri, −Rr), where R = a − b, as long as no clamping occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample qualifier for the inputs below |
| inv | input | 1 | 0 = forward factor, 1 = conjugate (inverse) factor |
| tw_idx | input | 5 | Twiddle index k, 0..31 |
| a_re | input | 16 | First sample, real part, signed |
| a_im | input | 16 | First sample, imaginary part, signed |
| b_re | input | 16 | Second sample, real part, signed |
| b_im | input | 16 | Second sample, imaginary part, signed |
| out_valid | output | 1 | Results on the four outputs below are new this cycle |
| up_re | output | 16 | Halved sum, real part |
| up_im | output | 16 | Halved sum, imaginary part |
| lo_re | output | 16 | Rotated difference, real part |
| lo_im | output | 16 | Rotated difference, imaginary part |

## Verification
A corrupted twiddle entry or a wrong sign in one of the regrouped terms appears on the lower leg exactly three edges after the offending sample is accepted. It usually appears in only one of the two parts, so both parts are compared for every index and in both directions. A valid bit lost or duplicated in the stage chain appears as `out_valid` out of step at once. A stage register that loads on an idle cycle appears as a change of the data outputs while `out_valid` is low. Clamping faults only surface with extreme differences, so directed rail-to-rail inputs are mixed into the random traffic.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  localparam int PTS     = 64;
  localparam int HALF_N  = PTS / 2;
  localparam int QTR     = PTS / 4;
  localparam int IDX_W   = $clog2(HALF_N);
  localparam int TW_W    = 16;
  localparam int TW_FRAC = 14;

  typedef logic signed [TW_W-1:0] tw_t;

  typedef struct packed {
    tw_t re;
    tw_t im;
  } tw_pair_t;

  // cos(pi*j/32) in Q1.14 for one quarter wave, j = 0..16
  function automatic tw_t quarter_cos(input int unsigned j);
    case (j)
      0:       return 16'sd16384;
      1:       return 16'sd16305;
      2:       return 16'sd16069;
      3:       return 16'sd15679;
      4:       return 16'sd15137;
      5:       return 16'sd14449;
      6:       return 16'sd13623;
      7:       return 16'sd12665;
      8:       return 16'sd11585;
      9:       return 16'sd10394;
      10:      return 16'sd9102;
      11:      return 16'sd7723;
      12:      return 16'sd6270;
      13:      return 16'sd4756;
      14:      return 16'sd3196;
      15:      return 16'sd1606;
      default: return 16'sd0;
    endcase
  endfunction

  // forward factor exp(-j*2*pi*k/PTS) folded from the quarter wave
  function automatic tw_pair_t fwd_twiddle(input int unsigned k);
    tw_pair_t w;
    if (k <= QTR) begin
      w.re = quarter_cos(k);
      w.im = -quarter_cos(QTR - k);
    end else begin
      w.re = -quarter_cos(HALF_N - k);
      w.im = -quarter_cos(k - QTR);
    end
    return w;
  endfunction
endpackage

// File: rtl/bfly_twiddle_rom.sv
module bfly_twiddle_rom
  import bfly_pkg::*;
#(
  parameter int IW = IDX_W
) (
  input  logic [IW-1:0] idx,
  input  logic          conj,
  output tw_t           w_re,
  output tw_t           w_im
);
  localparam int ENTRIES = 1 << IW;

  tw_pair_t table_w [ENTRIES];

  for (genvar gk = 0; gk < ENTRIES; gk++) begin : g_entry
    assign table_w[gk] = fwd_twiddle(gk);
  end

  tw_pair_t sel;
  assign sel  = table_w[idx];
  assign w_re = sel.re;
  assign w_im = conj ? -sel.im : sel.im;
endmodule

// File: rtl/bfly_front.sv
module bfly_front
  import bfly_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] a_v [2],
  input  logic signed [DW-1:0] b_v [2],
  input  tw_t                  w_in_re,
  input  tw_t                  w_in_im,
  output logic signed [DW:0]   sum_q [2],
  output logic signed [DW:0]   dif_q [2],
  output tw_t                  w_q_re,
  output tw_t                  w_q_im
);
  localparam int EW = DW + 1;

  for (genvar gl = 0; gl < 2; gl++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_q[gl] <= '0;
        dif_q[gl] <= '0;
      end else if (en) begin
        sum_q[gl] <= EW'(a_v[gl]) + EW'(b_v[gl]);
        dif_q[gl] <= EW'(a_v[gl]) - EW'(b_v[gl]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q_re <= '0;
      w_q_im <= '0;
    end else if (en) begin
      w_q_re <= w_in_re;
      w_q_im <= w_in_im;
    end
  end
endmodule

// File: rtl/bfly_cmul3.sv
module bfly_cmul3
  import bfly_pkg::*;
#(
  parameter int DW   = 16,
  parameter int FRAC = TW_FRAC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_mul,
  input  logic                 en_sum,
  input  logic signed [DW:0]   r_re,
  input  logic signed [DW:0]   r_im,
  input  tw_t                  w_re,
  input  tw_t                  w_im,
  output logic signed [DW-1:0] y_re,
  output logic signed [DW-1:0] y_im,
  output logic                 clip_re,
  output logic                 clip_im
);
  localparam int ED = DW + 2;
  localparam int WD = TW_W + 1;
  localparam int PW = ED + TW_W;
  localparam int AW = PW + 1;
  localparam logic signed [AW-1:0] RND  = AW'(1) <<< (FRAC - 1);
  localparam logic signed [AW-1:0] MAXV = AW'((1 <<< (DW - 1)) - 1);
  localparam logic signed [AW-1:0] MINV = -MAXV - AW'(1);

  function automatic logic signed [AW-1:0] descale(input logic signed [AW-1:0] x);
    return (x + RND) >>> FRAC;
  endfunction

  function automatic logic beyond(input logic signed [AW-1:0] x);
    return (x > MAXV) || (x < MINV);
  endfunction

  function automatic logic signed [DW-1:0] clamp(input logic signed [AW-1:0] x);
    if (x > MAXV)      return MAXV[DW-1:0];
    else if (x < MINV) return MINV[DW-1:0];
    else               return x[DW-1:0];
  endfunction

  // regrouped operands: one shared term and two per-part terms
  logic signed [ED-1:0] r_gap;
  logic signed [WD-1:0] w_gap;
  logic signed [WD-1:0] w_tot;
  assign r_gap = ED'(r_re) - ED'(r_im);
  assign w_gap = WD'(w_re) - WD'(w_im);
  assign w_tot = WD'(w_re) + WD'(w_im);

  logic signed [PW-1:0] m_shared, m_re, m_im;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_shared <= '0;
      m_re     <= '0;
      m_im     <= '0;
    end else if (en_mul) begin
      m_shared <= PW'(r_gap) * PW'(w_im);
      m_re     <= PW'(r_re) * PW'(w_gap);
      m_im     <= PW'(r_im) * PW'(w_tot);
    end
  end

  logic signed [AW-1:0] acc_re, acc_im, sc_re, sc_im;
  assign acc_re = AW'(m_shared) + AW'(m_re);
  assign acc_im = AW'(m_shared) + AW'(m_im);
  assign sc_re  = descale(acc_re);
  assign sc_im  = descale(acc_im);

  assign clip_re = en_sum && beyond(sc_re);
  assign clip_im = en_sum && beyond(sc_im);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_re <= '0;
      y_im <= '0;
    end else if (en_sum) begin
      y_re <= clamp(sc_re);
      y_im <= clamp(sc_im);
    end
  end
endmodule

// File: rtl/bfly3m_pe.sv
module bfly3m_pe
  import bfly_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 inv,
  input  logic [IW-1:0]        tw_idx,
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  output logic                 out_valid,
  output logic signed [DW-1:0] up_re,
  output logic signed [DW-1:0] up_im,
  output logic signed [DW-1:0] lo_re,
  output logic signed [DW-1:0] lo_im
);
  localparam int LAT = 3;
  localparam int EW  = DW + 1;

  function automatic logic signed [DW-1:0] halve(input logic signed [EW-1:0] s);
    logic signed [EW-1:0] t;
    t = (s + EW'(1)) >>> 1;
    return t[DW-1:0];
  endfunction

  logic [LAT-1:0] vpipe;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vpipe <= '0;
    else        vpipe <= {vpipe[LAT-2:0], in_valid};
  end
  assign out_valid = vpipe[LAT-1];

  // named internal events for the checker
  tw_t  tw_re_w, tw_im_w;
  logic clip_re_w, clip_im_w;

  bfly_twiddle_rom #(.IW(IW)) rom_i (
    .idx  (tw_idx),
    .conj (inv),
    .w_re (tw_re_w),
    .w_im (tw_im_w)
  );

  logic signed [DW-1:0] a_v [2];
  logic signed [DW-1:0] b_v [2];
  assign a_v[0] = a_re;
  assign a_v[1] = a_im;
  assign b_v[0] = b_re;
  assign b_v[1] = b_im;

  logic signed [DW:0] sum_s1 [2];
  logic signed [DW:0] dif_s1 [2];
  tw_t w_s1_re, w_s1_im;

  bfly_front #(.DW(DW)) front_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (in_valid),
    .a_v     (a_v),
    .b_v     (b_v),
    .w_in_re (tw_re_w),
    .w_in_im (tw_im_w),
    .sum_q   (sum_s1),
    .dif_q   (dif_s1),
    .w_q_re  (w_s1_re),
    .w_q_im  (w_s1_im)
  );

  bfly_cmul3 #(.DW(DW)) cmul_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_mul  (vpipe[0]),
    .en_sum  (vpipe[1]),
    .r_re    (dif_s1[0]),
    .r_im    (dif_s1[1]),
    .w_re    (w_s1_re),
    .w_im    (w_s1_im),
    .y_re    (lo_re),
    .y_im    (lo_im),
    .clip_re (clip_re_w),
    .clip_im (clip_im_w)
  );

  // upper leg: halve in stage two, align with the lower leg in stage three
  logic signed [DW-1:0] up_s2 [2];
  logic signed [DW-1:0] up_s3 [2];
  for (genvar gl = 0; gl < 2; gl++) begin : g_up
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        up_s2[gl] <= '0;
        up_s3[gl] <= '0;
      end else begin
        if (vpipe[0]) up_s2[gl] <= halve(sum_s1[gl]);
        if (vpipe[1]) up_s3[gl] <= up_s2[gl];
      end
    end
  end
  assign up_re = up_s3[0];
  assign up_im = up_s3[1];
endmodule

// File: rtl/bfly3m_pe_chk.sv
module bfly3m_pe_chk
  import bfly_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = IDX_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [IW-1:0]        tw_idx,
  input logic                 out_valid,
  input logic signed [DW-1:0] up_re,
  input logic signed [DW-1:0] up_im,
  input logic signed [DW-1:0] lo_re,
  input logic signed [DW-1:0] lo_im,
  input tw_t                  tw_re_w,
  input tw_t                  tw_im_w,
  input logic                 clip_re_w,
  input logic                 clip_im_w
);
  localparam logic signed [DW-1:0] TOP = DW'((1 <<< (DW - 1)) - 1);
  localparam logic signed [DW-1:0] BOT = -TOP - DW'(1);
  localparam tw_t UNITY = tw_t'(1 <<< TW_FRAC);

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!out_valid && up_re == '0 && up_im == '0 &&
                                lo_re == '0 && lo_im == '0)
        else $error("reset state not clear");
    end
  end

  // R2
  p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R9
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && !out_valid) |->
      ($stable(up_re) && $stable(up_im) && $stable(lo_re) && $stable(lo_im)));

  // R8
  p_clip_rail_re_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clip_re_w |=> (lo_re == TOP || lo_re == BOT));
  p_clip_rail_im_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clip_im_w |=> (lo_im == TOP || lo_im == BOT));

  // R6
  always @(posedge clk) begin
    if (rst_n) begin
      p_tw_unit_r6: assert (tw_idx != '0 || (tw_re_w == UNITY && tw_im_w == '0))
        else $error("index zero is not unity");
      p_tw_range_r6: assert (tw_re_w <= UNITY && tw_re_w >= -UNITY &&
                             tw_im_w <= UNITY && tw_im_w >= -UNITY)
        else $error("twiddle outside unit range");
    end
  end
endmodule

bind bfly3m_pe bfly3m_pe_chk #(.DW(DW), .IW(IW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .tw_idx    (tw_idx),
  .out_valid (out_valid),
  .up_re     (up_re),
  .up_im     (up_im),
  .lo_re     (lo_re),
  .lo_im     (lo_im),
  .tw_re_w   (tw_re_w),
  .tw_im_w   (tw_im_w),
  .clip_re_w (clip_re_w),
  .clip_im_w (clip_im_w)
);

// File: tb/bfly3m_pe_tb_top.sv
module bfly3m_pe_tb_top;
  typedef struct {
    int    ur;
    int    ui;
    int    lr;
    int    li;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic inv = 1'b0;
  logic [4:0] tw_idx = '0;
  logic signed [15:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
  logic out_valid;
  logic signed [15:0] up_re, up_im, lo_re, lo_im;

  int n_chk = 0;
  int n_bad = 0;
  bit checking = 1'b0;
  string cur_tag = "";

  always #4 clk = ~clk;

  bfly3m_pe dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .inv(inv), .tw_idx(tw_idx),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .out_valid(out_valid), .up_re(up_re), .up_im(up_im), .lo_re(lo_re), .lo_im(lo_im)
  );

  function automatic int rnd_r(input real x);
    return $rtoi($floor(x + 0.5));
  endfunction

  function automatic int clip16(input longint x);
    if (x > 32767)  return 32767;
    if (x < -32768) return -32768;
    return int'(x);
  endfunction

  // straightforward four-product reference
  function automatic exp_t model(input int ar, input int ai, input int br, input int bi,
                                 input int k, input bit conj, input string t);
    exp_t e;
    real ang;
    int wr, wi;
    longint rr, ri, pr, pim, sr, si;
    ang = 2.0 * 3.14159265358979 * real'(k) / 64.0;
    wr = rnd_r(16384.0 * $cos(ang));
    wi = -rnd_r(16384.0 * $sin(ang));
    if (conj) wi = -wi;
    rr = longint'(ar - br);
    ri = longint'(ai - bi);
    pr = rr * wr - ri * wi;
    pim = rr * wi + ri * wr;
    e.lr = clip16((pr + 8192) >>> 14);
    e.li = clip16((pim + 8192) >>> 14);
    sr = longint'(ar + br + 1);
    si = longint'(ai + bi + 1);
    e.ur = int'((sr - (sr & 1)) / 2);
    e.ui = int'((si - (si & 1)) / 2);
    e.tag = t;
    return e;
  endfunction

  bit   vq [3];
  exp_t dq [3];
  exp_t held;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) vq[i] <= 1'b0;
    end else begin
      vq[2] <= vq[1];
      vq[1] <= vq[0];
      vq[0] <= in_valid;
      dq[2] <= dq[1];
      dq[1] <= dq[0];
      dq[0] <= model(int'(a_re), int'(a_im), int'(b_re), int'(b_im),
                     int'(tw_idx), inv, cur_tag);
    end
  end

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      check("R2 out_valid", int'(out_valid), int'(vq[2]));
      if (vq[2]) begin
        held = dq[2];
      end else begin
        held.tag = "R9 R10 idle hold";
      end
      check({"R3 up_re ", held.tag}, int'(up_re), held.ur);
      check({"R3 up_im ", held.tag}, int'(up_im), held.ui);
      check({"R4 lo_re ", held.tag}, int'(lo_re), held.lr);
      check({"R5 lo_im ", held.tag}, int'(lo_im), held.li);
    end
  end

  task automatic drive(input bit v, input bit c, input int k,
                       input int ar, input int ai, input int br, input int bi,
                       input string t);
    @(negedge clk);
    in_valid = v;
    inv      = c;
    tw_idx   = 5'(k);
    a_re = 16'(ar); a_im = 16'(ai); b_re = 16'(br); b_im = 16'(bi);
    cur_tag  = t;
  endtask

  function automatic int rs16();
    return int'($signed(16'($urandom)));
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'd20517);
    held = '{0, 0, 0, 0, "reset"};
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 up_re", int'(up_re), 0);
    check("R1 up_im", int'(up_im), 0);
    check("R1 lo_re", int'(lo_re), 0);
    check("R1 lo_im", int'(lo_im), 0);
    rst_n = 1'b1;
    checking = 1'b1;

    // R6 and R7: unit sample exposes each table entry in both directions
    for (int k = 0; k < 32; k++) begin
      drive(1, 0, k, 16384, 0, 0, 0, "R6 table fwd");
      drive(1, 1, k, 16384, 0, 0, 0, "R7 table conj");
    end
    // R11: pass-through and quarter turn
    for (int i = 0; i < 12; i++) begin
      drive(1, 0, 0, rs16() / 2, rs16() / 2, rs16() / 2, rs16() / 2, "R11 k0 pass");
      drive(1, 0, 16, rs16() / 2, rs16() / 2, rs16() / 2, rs16() / 2, "R11 k16 turn");
    end
    // R8: rail-to-rail differences
    drive(1, 0, 4, 32767, 32767, -32768, -32768, "R8 clip pos");
    drive(1, 0, 4, -32768, -32768, 32767, 32767, "R8 clip neg");
    drive(1, 1, 12, 32767, -32768, -32768, 32767, "R8 clip conj");
    drive(1, 0, 0, 32767, -32768, -32768, 32767, "R8 clip k0");
    drive(1, 0, 8, -32768, -32768, -32768, -32768, "R3 sum min");
    drive(1, 0, 8, 32767, 32767, 32767, 32767, "R3 sum max");
    // R10: idle cycles with live data must not leak
    for (int i = 0; i < 6; i++)
      drive(0, $urandom % 2, $urandom % 32, rs16(), rs16(), rs16(), rs16(), "R10 ignored");
    drive(1, 0, 5, 100, -200, 300, -400, "R10 after idle");
    // random traffic with gaps
    for (int i = 0; i < 3000; i++)
      drive(($urandom % 4) != 0, $urandom % 2, $urandom % 32,
            rs16(), rs16(), rs16(), rs16(), "R4 R5 random");
    drive(0, 0, 0, 0, 0, 0, 0, "drain");
    repeat (6) @(negedge clk);
    finish_run();
  end
endmodule